// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register Bank

This block is the synchronous digital front end of an eight-channel, 13-bit voltage-output converter. A host places a code on a parallel data bus and a channel number on a 3-bit address. It then drives an active-low chip select and an active-low write strobe. While both strobes are low, the addressed channel's input register is loaded on every clock. Each channel also has a second register, the DAC register, that feeds the converter. Four active-low load lines control the DAC registers, one line for each pair of channels. The host can fill several input registers first and then release the new codes to many channels in the same cycle.

Each stage is "transparent" while its enable condition holds. This is modelled as a register that loads on every clock edge while the condition is true, so a value appears one cycle after it is sampled. When a pair's load line is low during a write, the bus code reaches that pair's DAC register directly, with the same one-cycle lag. An active-low clear has priority over every other control. While clear is low, a ground flag tells the converter to drive its outputs to analog ground, and every register is filled with the mid-scale code 0x1000. When clear is released, that code remains in all registers.

Codes are stored as offset binary. A mode input lets the host write two's-complement values instead; in that mode the most significant bit of the bus word is inverted before it is stored.

Top module: `dac_dbuf_bank`

## Requirements
- R1: The address selects the input register that a write loads. Address 0 selects channel A and address 7 selects channel H, with the channels in order in between. A write loads no other channel.
- R2: An input register loads only on clock edges where chip select and write are both sampled low. If either strobe is high, the register keeps its value whatever the bus carries.
- R3: While a pair's load line is low, each DAC register in that pair takes its input register's value at each edge, so it is visible one cycle later. While the load line is high, the DAC register holds.
- R4: Load line bit 0 serves channels A and B, bit 1 serves C and D, bit 2 serves E and F, and bit 3 serves G and H. A load line has no effect on channels outside its pair.
- R5: If a write and the load line of the addressed channel's pair are active at the same edge, that DAC register takes the converted bus code directly at that edge.
- R6: At each edge where clear is sampled low, out_at_ground goes high and every DAC code becomes 0x1000, whatever the strobes and load lines do. At an edge where clear is high, out_at_ground goes low.
- R7: After clear is released, every input register holds 0x1000, so a later load with no write gives 0x1000 on every channel.
- R8: When twos_mode is 1, bit 12 of the bus word is inverted before it is stored. When twos_mode is 0, the word is stored unchanged.
- R9: Asynchronous reset sets every DAC code to 0x1000 and sets out_at_ground to 0.
- R10: Several pairs whose load lines are low at the same edge all update at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Channel select for writes (0 = A … 7 = H) |
| data | input | 13 | Bus code |
| ld_n | input | 4 | Active-low load line, one per channel pair; bit p serves channels 2p and 2p+1 |
| clr_n | input | 1 | Active-low clear |
| twos_mode | input | 1 | 1 = bus carries two's complement, 0 = offset binary |
| dac_code | output | 104 | DAC register codes; channel c occupies bits [13c+12:13c] |
| out_at_ground | output | 1 | High while the outputs must sit at analog ground |

## Verification
The bench aims at the points where the double buffering is easiest to break. A write with only one strobe low must not reach the register; a design that ORs the strobes would load it. A load line must not update channels outside its own pair; a design with the wrong pair mapping would move the wrong channels. A write that coincides with its pair's load must show the bus code one cycle later; a design that passes the old input register value would show a stale code for one cycle. It also checks that clear wins over active writes and loads, and that clear leaves mid-scale in the input registers. A design that cleared only the DAC stage would show old codes on the first load after clear.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
    localparam int unsigned NUM_CH   = 8;
    localparam int unsigned CODE_W   = 13;
    localparam int unsigned PAIR_SZ  = 2;
endpackage

// File: rtl/dac_dbuf_decode.sv
module dac_dbuf_decode #(
    parameter int unsigned CH = dac_dbuf_pkg::NUM_CH,
    parameter int unsigned W  = dac_dbuf_pkg::CODE_W,
    localparam int unsigned AW = $clog2(CH)
) (
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  data,
    input  logic          twos_mode,
    output logic [CH-1:0] wr_hit,
    output logic [W-1:0]  bus_code
);
    logic strobe_on;

    // Both strobes low opens the bus path.
    assign strobe_on = ~cs_n & ~wr_n;

    // Two's complement to offset binary: flip the sign bit.
    assign bus_code = data ^ {twos_mode, {(W-1){1'b0}}};

    for (genvar c = 0; c < CH; c++) begin : g_sel
        assign wr_hit[c] = strobe_on && (addr == AW'(c));
    end
endmodule

// File: rtl/dac_dbuf_inreg.sv
module dac_dbuf_inreg #(
    parameter int unsigned CH = dac_dbuf_pkg::NUM_CH,
    parameter int unsigned W  = dac_dbuf_pkg::CODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic [CH-1:0]         wr_hit,
    input  logic [W-1:0]          bus_code,
    output logic [CH-1:0][W-1:0]  in_code
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [CH-1:0][W-1:0] code;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < CH; c++) begin
            if (!clr_n) begin
                st_d.code[c] = MID;
            end else if (wr_hit[c]) begin
                st_d.code[c] = bus_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: {CH{MID}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_code = st_q.code;
endmodule

// File: rtl/dac_dbuf_outreg.sv
module dac_dbuf_outreg #(
    parameter int unsigned CH   = dac_dbuf_pkg::NUM_CH,
    parameter int unsigned W    = dac_dbuf_pkg::CODE_W,
    parameter int unsigned PSZ  = dac_dbuf_pkg::PAIR_SZ,
    localparam int unsigned NP  = CH / PSZ
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic [CH-1:0]         wr_hit,
    input  logic [W-1:0]          bus_code,
    input  logic [NP-1:0]         ld_n,
    input  logic [CH-1:0][W-1:0]  in_code,
    output logic [CH*W-1:0]       dac_code,
    output logic                  out_at_ground
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [CH-1:0][W-1:0] code;
        logic                 gnd;
    } out_state_t;

    out_state_t      st_d, st_q;
    logic [CH-1:0]   ld_on;
    logic [CH-1:0][W-1:0] src;

    // Each channel's load enable comes from its pair's line; a write to the
    // same channel in the same cycle bypasses the input register.
    for (genvar c = 0; c < CH; c++) begin : g_ch
        assign ld_on[c] = ~ld_n[c / PSZ];
        assign src[c]   = wr_hit[c] ? bus_code : in_code[c];
        assign dac_code[c*W +: W] = st_q.code[c];
    end

    always_comb begin
        st_d     = st_q;
        st_d.gnd = ~clr_n;
        for (int c = 0; c < CH; c++) begin
            if (!clr_n) begin
                st_d.code[c] = MID;
            end else if (ld_on[c]) begin
                st_d.code[c] = src[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: {CH{MID}}, gnd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_at_ground = st_q.gnd;
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank #(
    parameter int unsigned CH  = dac_dbuf_pkg::NUM_CH,
    parameter int unsigned W   = dac_dbuf_pkg::CODE_W,
    parameter int unsigned PSZ = dac_dbuf_pkg::PAIR_SZ,
    localparam int unsigned AW = $clog2(CH),
    localparam int unsigned NP = CH / PSZ
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    data,
    input  logic [NP-1:0]   ld_n,
    input  logic            clr_n,
    input  logic            twos_mode,
    output logic [CH*W-1:0] dac_code,
    output logic            out_at_ground
);
    logic [CH-1:0]        wr_hit;
    logic [W-1:0]         bus_code;
    logic [CH-1:0][W-1:0] in_code;

    dac_dbuf_decode #(.CH(CH), .W(W)) u_dec (
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .data      (data),
        .twos_mode (twos_mode),
        .wr_hit    (wr_hit),
        .bus_code  (bus_code)
    );

    dac_dbuf_inreg #(.CH(CH), .W(W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .wr_hit   (wr_hit),
        .bus_code (bus_code),
        .in_code  (in_code)
    );

    dac_dbuf_outreg #(.CH(CH), .W(W), .PSZ(PSZ)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_n         (clr_n),
        .wr_hit        (wr_hit),
        .bus_code      (bus_code),
        .ld_n          (ld_n),
        .in_code       (in_code),
        .dac_code      (dac_code),
        .out_at_ground (out_at_ground)
    );
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk #(
    parameter int unsigned CH  = dac_dbuf_pkg::NUM_CH,
    parameter int unsigned W   = dac_dbuf_pkg::CODE_W,
    parameter int unsigned PSZ = dac_dbuf_pkg::PAIR_SZ,
    localparam int unsigned AW = $clog2(CH),
    localparam int unsigned NP = CH / PSZ
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            wr_n,
    input logic [AW-1:0]   addr,
    input logic [W-1:0]    data,
    input logic [NP-1:0]   ld_n,
    input logic            clr_n,
    input logic            twos_mode,
    input logic [CH*W-1:0] dac_code,
    input logic            out_at_ground
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    // R6
    clear_forces_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (out_at_ground && dac_code == {CH{MID}}));

    // R6
    ground_flag_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n |=> !out_at_ground);

    // R3
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&ld_n) && clr_n) |=> $stable(dac_code));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !cs_n && !wr_n && !ld_n[addr / AW'(PSZ)])
        |=> dac_code[$past(addr)*W +: W] ==
            ($past(data) ^ {$past(twos_mode), {(W-1){1'b0}}}));
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(.CH(CH), .W(W), .PSZ(PSZ)) u_chk (.*);

// File: tb/dac_dbuf_bank_test.sv
`timescale 1ns/1ps
module dac_dbuf_bank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, wr_n = 1'b1;
    logic [2:0]   addr = '0;
    logic [12:0]  data = '0;
    logic [3:0]   ld_n = 4'hF;
    logic         clr_n = 1'b1;
    logic         twos_mode = 1'b0;
    logic [103:0] dac_code;
    logic         out_at_ground;

    int checks = 0, failures = 0;
    bit done = 0;
    string phase = "R9";

    // behavioural reference
    int m_in[8], m_dac[8];
    int m_gnd;

    dac_dbuf_bank uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data(data), .ld_n(ld_n), .clr_n(clr_n), .twos_mode(twos_mode),
        .dac_code(dac_code), .out_at_ground(out_at_ground)
    );

    always #2 clk = ~clk;

    function automatic int chan(int c);
        return int'(dac_code[c*13 +: 13]);
    endfunction

    task automatic model_edge();
        int nin[8], ndac[8];
        int val;
        bit wsel;
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin m_in[c] = 4096; m_dac[c] = 4096; end
            m_gnd = 0;
            return;
        end
        if (!clr_n) begin
            for (int c = 0; c < 8; c++) begin m_in[c] = 4096; m_dac[c] = 4096; end
            m_gnd = 1;
            return;
        end
        m_gnd = 0;
        wsel = !cs_n && !wr_n;
        val = twos_mode ? (int'(data) ^ 4096) : int'(data);
        for (int c = 0; c < 8; c++) begin
            nin[c] = (wsel && int'(addr) == c) ? val : m_in[c];
            ndac[c] = m_dac[c];
            if (!ld_n[c/2]) ndac[c] = (wsel && int'(addr) == c) ? val : m_in[c];
        end
        m_in = nin;
        m_dac = ndac;
    endtask

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < 8; c++)
            check(phase, $sformatf("model ch%0d", c), chan(c), m_dac[c]);
        check(phase, "model ground flag", int'(out_at_ground), m_gnd);
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        cs_n = 1; wr_n = 1; ld_n = 4'hF;
    endtask

    task automatic wr(int a, int d);
        addr = 3'(a); data = 13'(d); cs_n = 0; wr_n = 0;
        cyc();
        cs_n = 1; wr_n = 1;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        phase = "R9";
        cyc(); cyc();
        rst_n = 1;
        @(negedge clk);
        for (int c = 0; c < 8; c++) check("R9", "reset code", chan(c), 13'h1000);
        check("R9", "reset flag", int'(out_at_ground), 0);

        // R1 / R3: fill all input registers with load high; DAC must hold
        phase = "R3";
        for (int c = 0; c < 8; c++) wr(c, 16 * c + 3);
        for (int c = 0; c < 8; c++) check("R3", "held during writes", chan(c), 13'h1000);

        // R2: single-strobe writes are ignored
        phase = "R2";
        addr = 3'd2; data = 13'h1ABC; cs_n = 1; wr_n = 0; cyc();
        cs_n = 0; wr_n = 1; cyc();
        idle();

        // R4: only pair A/B loads
        phase = "R4";
        ld_n = 4'b1110; cyc(); idle(); cyc();
        check("R4", "A loaded", chan(0), 3);
        check("R4", "B loaded", chan(1), 19);
        check("R4", "C untouched", chan(2), 13'h1000);
        check("R4", "H untouched", chan(7), 13'h1000);

        // R10 / R1 / R2: all pairs load together
        phase = "R10";
        ld_n = 4'b0000; cyc(); idle();
        for (int c = 0; c < 8; c++) check("R1", "addressed code", chan(c), 16 * c + 3);

        // R3: follow while load held low over several writes
        phase = "R3";
        ld_n = 4'b1011;
        wr(4, 13'h0777); wr(5, 13'h0555); wr(0, 13'h0111);
        idle(); cyc();
        check("R3", "E follows", chan(4), 13'h0777);
        check("R3", "A held", chan(0), 3);

        // R5: pass-through in the write cycle
        phase = "R5";
        ld_n = 4'b1101; addr = 3'd3; data = 13'h0ACE; cs_n = 0; wr_n = 0;
        cyc();
        check("R5", "D direct", chan(3), 13'h0ACE);
        check("R5", "C unchanged", chan(2), 35);
        idle();

        // R8: two's complement conversion
        phase = "R8";
        twos_mode = 1;
        wr(6, 13'h0005); wr(7, 13'h1FFF);
        twos_mode = 0;
        ld_n = 4'b0111; cyc(); idle(); cyc();
        check("R8", "G +5", chan(6), 13'h1005);
        check("R8", "H -1", chan(7), 13'h0FFF);

        // R6: clear overrides active write and loads
        phase = "R6";
        clr_n = 0; ld_n = 4'b0000; addr = 3'd1; data = 13'h0042; cs_n = 0; wr_n = 0;
        cyc(); cyc();
        check("R6", "ground flag", int'(out_at_ground), 1);
        for (int c = 0; c < 8; c++) check("R6", "clear code", chan(c), 13'h1000);
        idle(); clr_n = 1; cyc();
        check("R6", "flag released", int'(out_at_ground), 0);

        // R7: input registers were cleared too
        phase = "R7";
        ld_n = 4'b0000; cyc(); idle(); cyc();
        for (int c = 0; c < 8; c++) check("R7", "mid after clear", chan(c), 13'h1000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule